// File: doc/BRIEF.md
# Decimal-Capable 8-bit ALU

This block is the arithmetic and logic datapath of an 8-bit accumulator machine. In one pass it takes an operation code, the accumulator value, a memory operand, the current status flags and the decimal-mode bit. It produces the 8-bit result, the new N, V, Z and C flags, and a mask that marks which of those four flags the operation updates. Any flag outside the mask is passed through unchanged.

Addition and subtraction work either in plain binary or on packed BCD digits. The decimal forms add a correction step to each nibble. Compare and bit-test change only flags and return the accumulator unchanged. The four shifts and rotates act on the memory operand, so the sequencer chooses what to shift by routing it to `m`.

The datapath is combinational. A single register stage at its output captures one operation per cycle when `in_valid` is high, and the results appear on the outputs on the next cycle.

Top module: `dec_alu`

## Requirements
- R1: Flag vectors use bit 3 = N, bit 2 = V, bit 1 = Z and bit 0 = C, in `flags_in`, `flags_out` and `upd_mask`. Op 0 (add) with `dec_mode`=0 forms the 9-bit sum s = a + m + C. The result is s[7:0] and C = s[8]. V is bit 7 of ((s ^ a) & (s ^ m)). N is result bit 7 and Z is (result == 0). The mask is 4'b1111.
- R2: Op 0 with `dec_mode`=1 adds the low nibbles with the carry into a 5-bit sum L. When L > 9 the low digit becomes (L + 6) mod 16 and a carry of 1 enters the high nibble sum H. When H > 9 the high digit becomes (H + 6) mod 16 and C = 1; otherwise C = 0.
- R3: In decimal add, N, Z and V are taken from the uncorrected byte u = {H[3:0], L[3:0]}. N = u[7], Z = (u == 0), and V is bit 7 of ((u ^ a) & (u ^ m)).
- R4: Op 1 (subtract) forms s = a + (m ^ 8'hFF) + C. In both modes N, Z, V and C come from this binary sum, with V using the inverted operand. In binary mode the result is s[7:0].
- R5: Op 1 with `dec_mode`=1 also forms the low-nibble sum L = a[3:0] + ~m[3:0] + C. The low digit is L[3:0], less 6 when L[4] = 0. The high digit is s[7:4], less 6 (mod 16) when s[8] = 0.
- R6: Ops 2, 3 and 4 give a & m, a | m and a ^ m. They update only N and Z (mask 4'b1010).
- R7: Op 5 (shift left) gives {m[6:0],0} with C = m[7]. Op 6 (shift right) gives {0,m[7:1]} with C = m[0], so N is cleared. Both have mask 4'b1011.
- R8: Op 7 (rotate left) gives {m[6:0],C} with new C = m[7]. Op 8 (rotate right) gives {C,m[7:1]} with new C = m[0]. Both have mask 4'b1011.
- R9: Op 9 (compare) sets N, Z and C from s = a + ~m + 1 (C = s[8]). It leaves V unchanged, returns a as the result, and has mask 4'b1011.
- R10: Op 10 (bit test) sets Z = ((a & m) == 0), N = m[7] and V = m[6]. It leaves C unchanged, returns a, and has mask 4'b1110.
- R11: Op codes 11 to 15 return a, give mask 4'b0000 and give `flags_out` equal to `flags_in`.
- R12: Outputs are registered. `out_valid` is `in_valid` delayed by one clock. While `rst_n` is low, every output is 0.
- R13: For every operation, each flag bit whose mask bit is 0 equals the corresponding bit of `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| a | input | 8 | Accumulator operand |
| m | input | 8 | Memory operand |
| flags_in | input | 4 | Incoming {N,V,Z,C} |
| dec_mode | input | 1 | Packed-BCD mode for add and subtract |
| out_valid | output | 1 | Registered result valid |
| result | output | 8 | Registered result |
| flags_out | output | 4 | Registered {N,V,Z,C} |
| upd_mask | output | 4 | Registered update mask {N,V,Z,C} |

## Verification
The datapath holds no state, so a wrong internal value shows at the ports exactly one clock after the operation is presented. It cannot hide or carry over into a later operation. A missing digit correction shows as a non-BCD nibble or a lost carry. A flag taken from the wrong intermediate value shows in N, Z or V only for decimal operands whose corrected and uncorrected bytes differ. Directed decimal carry and borrow cases are therefore mixed with a long stream of random operations, and each result is compared in the cycle it appears.

// File: rtl/dec_alu_pkg.sv
package dec_alu_pkg;

    parameter int DW  = 8;
    parameter int NIB = DW / 2;
    parameter int FW  = 4;

    localparam int FL_N = 3;
    localparam int FL_V = 2;
    localparam int FL_Z = 1;
    localparam int FL_C = 0;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_ROL = 4'd7,
        OP_ROR = 4'd8,
        OP_CMP = 4'd9,
        OP_BIT = 4'd10
    } alu_op_e;

    localparam logic [FW-1:0] MASK_ALL   = 4'b1111;
    localparam logic [FW-1:0] MASK_NZ    = 4'b1010;
    localparam logic [FW-1:0] MASK_NZC   = 4'b1011;
    localparam logic [FW-1:0] MASK_NVZ   = 4'b1110;
    localparam logic [FW-1:0] MASK_NONE  = 4'b0000;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] res;
        logic [FW-1:0] flags;
        logic [FW-1:0] mask;
    } alu_out_t;

endpackage

// File: rtl/dec_alu_addsub.sv
module dec_alu_addsub
    import dec_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          c_in,
    input  logic          dec,
    input  logic          sub,
    output logic [DW-1:0] res,
    output logic          n_out,
    output logic          v_out,
    output logic          z_out,
    output logic          c_out
);
    localparam logic [NIB:0] DIGIT_MAX = 5'd9;
    localparam logic [NIB:0] FIX       = 5'd6;

    logic [DW-1:0]  m_eff;
    logic [DW:0]    bin_sum;
    logic [NIB:0]   lo_sum;
    logic [NIB:0]   hi_sum;
    logic           lo_carry;
    logic           hi_carry;
    logic [NIB:0]   lo_fix;
    logic [NIB:0]   hi_fix;
    logic [DW-1:0]  mid;
    logic [NIB-1:0] lo_sub;
    logic [NIB-1:0] hi_sub;
    logic [DW-1:0]  flag_src;
    logic [DW-1:0]  ovf_terms;

    always_comb begin
        m_eff    = sub ? ~m : m;
        bin_sum  = {1'b0, a} + {1'b0, m_eff} + {{DW{1'b0}}, c_in};
        lo_sum   = {1'b0, a[NIB-1:0]} + {1'b0, m_eff[NIB-1:0]} + {{NIB{1'b0}}, c_in};

        // decimal add: correct low digit, then high digit
        lo_carry = lo_sum > DIGIT_MAX;
        lo_fix   = lo_carry ? lo_sum + FIX : lo_sum;
        hi_sum   = {1'b0, a[DW-1:NIB]} + {1'b0, m[DW-1:NIB]} + {{NIB{1'b0}}, lo_carry};
        hi_carry = hi_sum > DIGIT_MAX;
        hi_fix   = hi_carry ? hi_sum + FIX : hi_sum;
        mid      = {hi_sum[NIB-1:0], lo_sum[NIB-1:0]};

        // decimal subtract: remove 6 from each digit that borrowed
        lo_sub   = lo_sum[NIB] ? lo_sum[NIB-1:0] : lo_sum[NIB-1:0] - FIX[NIB-1:0];
        hi_sub   = bin_sum[DW] ? bin_sum[DW-1:NIB] : bin_sum[DW-1:NIB] - FIX[NIB-1:0];

        if (dec && !sub) begin
            res      = {hi_fix[NIB-1:0], lo_fix[NIB-1:0]};
            flag_src = mid;
            c_out    = hi_carry;
        end else if (dec) begin
            res      = {hi_sub, lo_sub};
            flag_src = bin_sum[DW-1:0];
            c_out    = bin_sum[DW];
        end else begin
            res      = bin_sum[DW-1:0];
            flag_src = bin_sum[DW-1:0];
            c_out    = bin_sum[DW];
        end

        ovf_terms = (flag_src ^ a) & (flag_src ^ m_eff);
        n_out     = flag_src[DW-1];
        z_out     = (flag_src == '0);
        v_out     = ovf_terms[DW-1];
    end
endmodule

// File: rtl/dec_alu_logic.sv
module dec_alu_logic
    import dec_alu_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output logic          c_out,
    output logic          is_shift
);
    logic [DW-1:0] left_v;
    logic [DW-1:0] right_v;
    logic          fill_l;
    logic          fill_r;

    always_comb begin
        fill_l  = (op == OP_ROL) ? c_in : 1'b0;
        fill_r  = (op == OP_ROR) ? c_in : 1'b0;
        left_v  = {m[DW-2:0], fill_l};
        right_v = {fill_r, m[DW-1:1]};
        res      = a;
        c_out    = c_in;
        is_shift = 1'b0;
        case (op)
            OP_AND: res = a & m;
            OP_OR:  res = a | m;
            OP_XOR: res = a ^ m;
            OP_SHL, OP_ROL: begin
                res      = left_v;
                c_out    = m[DW-1];
                is_shift = 1'b1;
            end
            OP_SHR, OP_ROR: begin
                res      = right_v;
                c_out    = m[0];
                is_shift = 1'b1;
            end
            default: res = a;
        endcase
    end
endmodule

// File: rtl/dec_alu.sv
module dec_alu
    import dec_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic [7:0]    a,
    input  logic [7:0]    m,
    input  logic [3:0]    flags_in,
    input  logic          dec_mode,
    output logic          out_valid,
    output logic [7:0]    result,
    output logic [3:0]    flags_out,
    output logic [3:0]    upd_mask
);
    logic          is_cmp;
    logic          as_sub;
    logic          as_cin;
    logic          as_dec;
    logic [DW-1:0] as_res;
    logic          as_n, as_v, as_z, as_c;
    logic [DW-1:0] lg_res;
    logic          lg_c;
    logic          lg_shift;

    alu_out_t      d_d;
    alu_out_t      d_q;
    logic [FW-1:0] new_f;

    assign is_cmp = (op == OP_CMP);
    assign as_sub = (op == OP_SUB) || is_cmp;
    assign as_cin = is_cmp ? 1'b1 : flags_in[FL_C];
    assign as_dec = dec_mode && !is_cmp;

    dec_alu_addsub u_addsub (
        .a     (a),
        .m     (m),
        .c_in  (as_cin),
        .dec   (as_dec),
        .sub   (as_sub),
        .res   (as_res),
        .n_out (as_n),
        .v_out (as_v),
        .z_out (as_z),
        .c_out (as_c)
    );

    dec_alu_logic u_logic (
        .op       (op),
        .a        (a),
        .m        (m),
        .c_in     (flags_in[FL_C]),
        .res      (lg_res),
        .c_out    (lg_c),
        .is_shift (lg_shift)
    );

    always_comb begin
        d_d.valid = in_valid;
        d_d.res   = a;
        d_d.mask  = MASK_NONE;
        new_f     = flags_in;
        case (op)
            OP_ADD, OP_SUB: begin
                d_d.res     = as_res;
                d_d.mask    = MASK_ALL;
                new_f       = {as_n, as_v, as_z, as_c};
            end
            OP_CMP: begin
                d_d.mask    = MASK_NZC;
                new_f[FL_N] = as_n;
                new_f[FL_Z] = as_z;
                new_f[FL_C] = as_c;
            end
            OP_AND, OP_OR, OP_XOR: begin
                d_d.res     = lg_res;
                d_d.mask    = MASK_NZ;
                new_f[FL_N] = lg_res[DW-1];
                new_f[FL_Z] = (lg_res == '0);
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                d_d.res     = lg_res;
                d_d.mask    = lg_shift ? MASK_NZC : MASK_NONE;
                new_f[FL_N] = lg_res[DW-1];
                new_f[FL_Z] = (lg_res == '0);
                new_f[FL_C] = lg_c;
            end
            OP_BIT: begin
                d_d.mask    = MASK_NVZ;
                new_f[FL_N] = m[DW-1];
                new_f[FL_V] = m[DW-2];
                new_f[FL_Z] = ((a & m) == '0);
            end
            default: begin
                d_d.res  = a;
                d_d.mask = MASK_NONE;
            end
        endcase
        d_d.flags = (d_d.mask & new_f) | (~d_d.mask & flags_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign out_valid = d_q.valid;
    assign result    = d_q.res;
    assign flags_out = d_q.flags;
    assign upd_mask  = d_q.mask;
endmodule

// File: rtl/dec_alu_chk.sv
module dec_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [3:0] op,
    input logic [7:0] a,
    input logic [3:0] flags_in,
    input logic       out_valid,
    input logic [7:0] result,
    input logic [3:0] flags_out,
    input logic [3:0] upd_mask
);
    // R12
    p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R13
    p_flag_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((flags_out & ~upd_mask) == ($past(flags_in) & ~upd_mask)));

    // R11
    p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd11) |=> (upd_mask == 4'b0000 && result == $past(a)));

    // R9
    p_cmp_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd9) |=> (upd_mask == 4'b1011 && result == $past(a)));

    // R7
    p_shr_clear_n_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd6) |=> !flags_out[3]);

    // R6
    p_logic_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd2 && op <= 4'd4) |=> (flags_out[1] == (result == 8'h00)));
endmodule

bind dec_alu dec_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out),
    .upd_mask  (upd_mask)
);

// File: tb/dec_alu_test.sv
`timescale 1ns/1ps
module dec_alu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] a = 8'd0;
    logic [7:0] m = 8'd0;
    logic [3:0] flags_in = 4'd0;
    logic       dec_mode = 1'b0;
    logic       out_valid;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic [3:0] upd_mask;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] r;
        logic [3:0] f;
        logic [3:0] k;
        string      tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    dec_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .m(m),
        .flags_in(flags_in), .dec_mode(dec_mode), .out_valid(out_valid),
        .result(result), .flags_out(flags_out), .upd_mask(upd_mask)
    );

    function automatic string op_tag(input logic [3:0] o, input logic dm);
        case (o)
            4'd0:  return dm ? "R2/R3 dec add" : "R1 add";
            4'd1:  return dm ? "R5 dec sub" : "R4 sub";
            4'd2, 4'd3, 4'd4: return "R6 logic";
            4'd5, 4'd6: return "R7 shift";
            4'd7, 4'd8: return "R8 rotate";
            4'd9:  return "R9 compare";
            4'd10: return "R10 bit test";
            default: return "R11 unused";
        endcase
    endfunction

    // expected values from the requirement text
    function automatic item_t model(input logic [3:0] o, input logic [7:0] av,
                                    input logic [7:0] mv, input logic [3:0] fi,
                                    input logic dm);
        item_t it;
        logic [8:0] s;
        logic [4:0] lo, hi;
        logic [7:0] u, mi, ov;
        logic [3:0] nf;
        logic lc, hc;
        it.r = av; it.k = 4'b0000; nf = fi;
        mi = ~mv;
        case (o)
            4'd0: begin
                it.k = 4'b1111;
                if (!dm) begin
                    s = {1'b0, av} + {1'b0, mv} + {8'd0, fi[0]};
                    it.r = s[7:0]; ov = (s[7:0] ^ av) & (s[7:0] ^ mv);
                    nf = {s[7], ov[7], s[7:0] == 8'h00, s[8]};
                end else begin
                    lo = {1'b0, av[3:0]} + {1'b0, mv[3:0]} + {4'd0, fi[0]};
                    lc = lo > 5'd9;
                    hi = {1'b0, av[7:4]} + {1'b0, mv[7:4]} + {4'd0, lc};
                    hc = hi > 5'd9;
                    u = {hi[3:0], lo[3:0]};
                    it.r[3:0] = lc ? lo[3:0] + 4'd6 : lo[3:0];
                    it.r[7:4] = hc ? hi[3:0] + 4'd6 : hi[3:0];
                    ov = (u ^ av) & (u ^ mv);
                    nf = {u[7], ov[7], u == 8'h00, hc};
                end
            end
            4'd1: begin
                it.k = 4'b1111;
                s = {1'b0, av} + {1'b0, mi} + {8'd0, fi[0]};
                lo = {1'b0, av[3:0]} + {1'b0, mi[3:0]} + {4'd0, fi[0]};
                ov = (s[7:0] ^ av) & (s[7:0] ^ mi);
                nf = {s[7], ov[7], s[7:0] == 8'h00, s[8]};
                it.r = s[7:0];
                if (dm) begin
                    it.r[3:0] = lo[4] ? lo[3:0] : lo[3:0] - 4'd6;
                    it.r[7:4] = s[8] ? s[7:4] : s[7:4] - 4'd6;
                end
            end
            4'd2, 4'd3, 4'd4: begin
                it.k = 4'b1010;
                it.r = (o == 4'd2) ? (av & mv) : (o == 4'd3) ? (av | mv) : (av ^ mv);
                nf[3] = it.r[7]; nf[1] = it.r == 8'h00;
            end
            4'd5, 4'd6, 4'd7, 4'd8: begin
                it.k = 4'b1011;
                case (o)
                    4'd5: begin it.r = {mv[6:0], 1'b0};  nf[0] = mv[7]; end
                    4'd6: begin it.r = {1'b0, mv[7:1]};  nf[0] = mv[0]; end
                    4'd7: begin it.r = {mv[6:0], fi[0]}; nf[0] = mv[7]; end
                    default: begin it.r = {fi[0], mv[7:1]}; nf[0] = mv[0]; end
                endcase
                nf[3] = it.r[7]; nf[1] = it.r == 8'h00;
            end
            4'd9: begin
                it.k = 4'b1011;
                s = {1'b0, av} + {1'b0, mi} + 9'd1;
                nf[3] = s[7]; nf[1] = s[7:0] == 8'h00; nf[0] = s[8];
            end
            4'd10: begin
                it.k = 4'b1110;
                nf[3] = mv[7]; nf[2] = mv[6]; nf[1] = (av & mv) == 8'h00;
            end
            default: ;
        endcase
        it.f = (it.k & nf) | (~it.k & fi);
        it.tag = op_tag(o, dm);
        return it;
    endfunction

    task automatic put(input logic [3:0] o, input logic [7:0] av, input logic [7:0] mv,
                       input logic [3:0] fi, input logic dm);
        @(negedge clk);
        op = o; a = av; m = mv; flags_in = fi; dec_mode = dm; in_valid = 1'b1;
        sb.push_back(model(o, av, mv, fi, dm));
    endtask

    task automatic put_fixed(input logic [3:0] o, input logic [7:0] av, input logic [7:0] mv,
                             input logic [3:0] fi, input logic dm, input logic [7:0] er,
                             input logic [3:0] ef, input logic [3:0] ek, input string tg);
        item_t it;
        @(negedge clk);
        op = o; a = av; m = mv; flags_in = fi; dec_mode = dm; in_valid = 1'b1;
        it.r = er; it.f = ef; it.k = ek; it.tag = tg;
        sb.push_back(it);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R12", "unexpected out_valid", 16'd1, 16'd0);
            end else begin
                item_t e;
                e = sb.pop_front();
                check(result == e.r && flags_out == e.f && upd_mask == e.k, e.tag,
                      "res/flags/mask",
                      {result, flags_out, upd_mask}, {e.r, e.f, e.k});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(out_valid == 1'b0 && result == 8'h00 && flags_out == 4'h0 && upd_mask == 4'h0,
              "R12", "reset outputs", {out_valid, result, flags_out, upd_mask}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 overflow into sign: 7F+01 -> 80, N=1 V=1 Z=0 C=0
        put_fixed(4'd0, 8'h7F, 8'h01, 4'b0000, 1'b0, 8'h80, 4'b1100, 4'b1111, "R1 add ovf");
        // R1 carry out and zero: FF+01 -> 00, Z=1 C=1
        put_fixed(4'd0, 8'hFF, 8'h01, 4'b0000, 1'b0, 8'h00, 4'b0011, 4'b1111, "R1 add carry");
        // R2/R3 decimal 58+46+1 -> 05 C=1, u=AF gives N=1 V=1
        put_fixed(4'd0, 8'h58, 8'h46, 4'b0001, 1'b1, 8'h05, 4'b1101, 4'b1111, "R2/R3 dec add");
        // R2 decimal 09+01 -> 10 no carry
        put_fixed(4'd0, 8'h09, 8'h01, 4'b0000, 1'b1, 8'h10, 4'b0000, 4'b1111, "R2 dec digit carry");
        // R5 decimal 12-21 (C=1) -> 91 with borrow
        put_fixed(4'd1, 8'h12, 8'h21, 4'b0001, 1'b1, 8'h91, 4'b1000, 4'b1111, "R5 dec sub");
        // R4 binary 05-05 (C=1) -> 00, Z=1 C=1
        put_fixed(4'd1, 8'h05, 8'h05, 4'b0001, 1'b0, 8'h00, 4'b0011, 4'b1111, "R4 sub zero");
        // R7 shift right of 01 -> 00, C=1 Z=1 N=0, V kept
        put_fixed(4'd6, 8'h00, 8'h01, 4'b1100, 1'b0, 8'h00, 4'b0111, 4'b1011, "R7 shr");
        // R8 rotate right of 00 with C=1 -> 80, C=0
        put_fixed(4'd8, 8'h00, 8'h00, 4'b0001, 1'b0, 8'h80, 4'b1000, 4'b1011, "R8 ror");
        // R9 compare 10 vs 10: Z=1 C=1, V kept, result = a
        put_fixed(4'd9, 8'h10, 8'h10, 4'b0100, 1'b1, 8'h10, 4'b0111, 4'b1011, "R9 cmp equal");
        // R10 bit test: a&m=0, m=C0 -> N=1 V=1 Z=1, C kept
        put_fixed(4'd10, 8'h0F, 8'hC0, 4'b0001, 1'b0, 8'h0F, 4'b1111, 4'b1110, "R10 bit");
        // R11 unused code keeps everything, R13 pass-through
        put_fixed(4'd13, 8'h5A, 8'hFF, 4'b1010, 1'b1, 8'h5A, 4'b1010, 4'b0000, "R11 unused");
        // R6 AND giving zero, V and C kept
        put_fixed(4'd2, 8'hF0, 8'h0F, 4'b1101, 1'b0, 8'h00, 4'b0111, 4'b1010, "R6 and zero");

        // every op code, both modes, valid BCD operands in decimal mode
        for (int o = 0; o < 16; o++) begin
            for (int dm = 0; dm < 2; dm++) begin
                put(o[3:0], 8'h99, 8'h01, 4'b0101, dm[0]);
                put(o[3:0], 8'h00, 8'h99, 4'b1010, dm[0]);
            end
        end

        // random stream, R13 pass-through across all ops
        for (int i = 0; i < 600; i++) begin
            logic [7:0] ra, rm;
            logic dm;
            dm = ($urandom_range(0, 1) == 1);
            ra = $urandom_range(0, 255);
            rm = $urandom_range(0, 255);
            if (dm) begin
                ra = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
                rm = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            end
            put(4'($urandom_range(0, 15)), ra, rm, 4'($urandom_range(0, 15)), dm);
            if ((i % 7) == 3) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R12 every issued operation produced exactly one valid result
        check(sb.size() == 0 && out_valid == 1'b0, "R12", "pending results",
              16'(sb.size()), 16'd0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) check(1'b0, "watchdog", "timeout", 16'd1, 16'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule